// File: doc/BRIEF.md
# Interleaved Two-Bank Flash Read Sequencer

This block connects a 32-bit read bus to a flash array that is split into two banks, each with its own read port. Even word addresses live in bank 0 and odd word addresses live in bank 1. When the flash needs a wait state, every access holds a bank address for two cycles. To hide that cost, each accepted read also starts the next sequential word in the other bank. A linear burst therefore returns one word per clock after its first word.

A configuration input selects zero or one wait state. With zero wait states, no word is fetched ahead and every read returns in the following cycle. The bus master presents word addresses with a valid/ready handshake and receives each word with a one-cycle valid strobe. There is no backpressure on the response. Each bank port gives a bank address and a start strobe. It returns read data that is only trustworthy once that address has been stable for the configured access time.

Top module: `flash_ilv_reader`

## Requirements
- R1: Word-address bit 0 picks the bank: 0 selects bank 0 and 1 selects bank 1. An access started on a bank shows the word address without bit 0 on that bank's address port, with its start strobe high, in the cycle after acceptance.
- R2: With zero wait states (cfg_one_ws = 0), req_ready stays high and rsp_valid is high in the cycle after each acceptance, so back-to-back reads complete one per cycle.
- R3: With one wait state (cfg_one_ws = 1), a read whose word is not held by its bank is a miss. For a miss, rsp_valid rises two cycles after acceptance and req_ready is low in the cycle between.
- R4: With one wait state, a read whose word its bank already holds, from a prefetch or from an earlier access, is a hit. A hit returns in the next cycle, and that bank's access is not restarted.
- R5: With one wait state, every acceptance of word N starts the other bank on word N+1 (modulo the address space) in the next cycle.
- R6: With one wait state, a run of consecutive word addresses returns one word per cycle after its first word.
- R7: During each rsp_valid cycle, rsp_data equals the stored word of the requested address.
- R8: After reset, rsp_valid is 0, req_ready is 1 and no bank holds a word, so the first one-wait-state read is a miss.
- R9: Any change of cfg_one_ws drops the words held by both banks, so the next one-wait-state read is a miss even for a word that was prefetched before the change.
- R10: With zero wait states, an acceptance starts only the addressed bank; no word is fetched ahead.
- R11: A one-wait-state read that is not the prefetched word is a miss, and the prefetched word is discarded. After the highest word address, word 0 is the prefetched word and hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_one_ws | input | 1 | 1 selects one wait state, 0 selects zero wait states |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW (12) | Requested word address |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_data | output | DW (32) | Read data word |
| bank0_addr | output | AW-1 | Bank 0 word address |
| bank0_start | output | 1 | Bank 0 begins a new access this cycle |
| bank0_rdata | input | DW | Bank 0 read data |
| bank1_addr | output | AW-1 | Bank 1 word address |
| bank1_start | output | 1 | Bank 1 begins a new access this cycle |
| bank1_rdata | input | DW | Bank 1 read data |

## Verification
A read accepted at edge k is due in the cycle after edge k. The exception is a one-wait-state miss, which is due one cycle later. The bench's bank models return inverted data until an address has been stable for the configured access time, so a response taken too early shows up as a data mismatch. The driver decides hit or miss from its own record of the held words at the negative edge before acceptance. It queues the expected word with its due cycle, and the monitor compares each response against that cycle and flags any item whose cycle passes without a response.

// File: rtl/fl_ilv_pkg.sv
package fl_ilv_pkg;

    typedef enum logic {
        WS_ZERO = 1'b0,
        WS_ONE  = 1'b1
    } ws_mode_e;

    typedef struct packed {
        logic wait1;   // one-wait-state miss: first cycle of the access
        logic pend;    // response is due this cycle
        logic bank;    // bank that supplies the response
    } ctl_state_t;

    typedef struct packed {
        ws_mode_e mode_seen;
    } top_state_t;

endpackage

// File: rtl/fl_ilv_bank_port.sv
module fl_ilv_bank_port #(
    parameter int BAW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic [BAW-1:0] launch_addr,
    input  logic           drop,
    output logic [BAW-1:0] addr_o,
    output logic           start_o,
    output logic           held_o
);

    typedef struct packed {
        logic [BAW-1:0] addr;
        logic           start;
        logic           held;
    } port_state_t;

    port_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = launch;
        if (launch) begin
            s_d.addr = launch_addr;
            s_d.held = 1'b1;
        end
        if (drop) begin
            s_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o  = s_q.addr;
    assign start_o = s_q.start;
    assign held_o  = s_q.held;

    // R1: a launch shows up on the port one cycle later with the same address
    p_launch_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (start_o && addr_o == $past(launch_addr)));

endmodule

// File: rtl/fl_ilv_seq_ctl.sv
module fl_ilv_seq_ctl
    import fl_ilv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic one_ws,
    input  logic req_valid,
    input  logic req_bank,
    input  logic hit,
    output logic req_ready,
    output logic accept,
    output logic rsp_valid,
    output logic rsp_bank
);

    ctl_state_t s_d, s_q;
    ws_mode_e   mode;

    assign mode      = ws_mode_e'(one_ws);
    assign req_ready = !s_q.wait1;
    assign accept    = req_valid && req_ready;

    always_comb begin
        s_d       = s_q;
        s_d.pend  = 1'b0;
        s_d.wait1 = 1'b0;
        if (s_q.wait1) begin
            s_d.pend = 1'b1;
        end else if (accept) begin
            s_d.bank = req_bank;
            if (mode == WS_ONE && !hit) begin
                s_d.wait1 = 1'b1;
            end else begin
                s_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.pend;
    assign rsp_bank  = s_q.bank;

    // R2: zero wait states answer in the next cycle
    p_zero_ws_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !one_ws) |=> rsp_valid);

    // R3: a miss idles one cycle with ready low, then answers
    p_miss_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && one_ws && !hit) |=> (!rsp_valid && !req_ready) ##1 rsp_valid);

    // R4: a hit answers in the next cycle from the requested bank
    p_hit_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && one_ws && hit) |=> (rsp_valid && rsp_bank == $past(req_bank)));

endmodule

// File: rtl/flash_ilv_reader.sv
module flash_ilv_reader
    import fl_ilv_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_one_ws,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-2:0] bank0_addr,
    output logic          bank0_start,
    input  logic [DW-1:0] bank0_rdata,
    output logic [AW-2:0] bank1_addr,
    output logic          bank1_start,
    input  logic [DW-1:0] bank1_rdata
);

    localparam int BAW    = AW - 1;
    localparam int NBANKS = 2;

    top_state_t     s_d, s_q;
    logic           cfg_chg;
    logic           drop;
    logic           accept;
    logic           hit;
    logic           rsp_bank;
    logic           req_bank;
    logic [BAW-1:0] req_word;
    logic [AW-1:0]  nxt_addr;
    logic [BAW-1:0] nxt_word;

    logic [BAW-1:0] bk_addr   [NBANKS];
    logic           bk_start  [NBANKS];
    logic           bk_held   [NBANKS];
    logic           launch_v  [NBANKS];
    logic [BAW-1:0] launch_a  [NBANKS];

    // configuration tracking
    always_comb begin
        s_d           = s_q;
        s_d.mode_seen = ws_mode_e'(cfg_one_ws);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_chg  = (ws_mode_e'(cfg_one_ws) != s_q.mode_seen);
    assign drop     = cfg_chg || !cfg_one_ws;

    assign req_bank = req_addr[0];
    assign req_word = req_addr[AW-1:1];
    assign nxt_addr = req_addr + AW'(1);
    assign nxt_word = nxt_addr[AW-1:1];

    assign hit = cfg_one_ws && !cfg_chg && bk_held[req_bank]
                 && (bk_addr[req_bank] == req_word);

    always_comb begin
        for (int i = 0; i < NBANKS; i++) begin
            if (i == int'(req_bank)) begin
                launch_v[i] = accept && !hit;
                launch_a[i] = req_word;
            end else begin
                launch_v[i] = accept && cfg_one_ws;
                launch_a[i] = nxt_word;
            end
        end
    end

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        fl_ilv_bank_port #(.BAW(BAW)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .launch      (launch_v[g]),
            .launch_addr (launch_a[g]),
            .drop        (drop),
            .addr_o      (bk_addr[g]),
            .start_o     (bk_start[g]),
            .held_o      (bk_held[g])
        );
    end

    fl_ilv_seq_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .one_ws    (cfg_one_ws),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .hit       (hit),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid),
        .rsp_bank  (rsp_bank)
    );

    assign bank0_addr  = bk_addr[0];
    assign bank0_start = bk_start[0];
    assign bank1_addr  = bk_addr[1];
    assign bank1_start = bk_start[1];
    assign rsp_data    = rsp_bank ? bank1_rdata : bank0_rdata;

    // R5: one-wait-state acceptance starts the other bank on the next word
    p_prefetch_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_one_ws) |=>
            ($past(req_bank) ? (bank0_start && bank0_addr == $past(nxt_word))
                             : (bank1_start && bank1_addr == $past(nxt_word))));

    // R10: zero wait states start exactly one bank per acceptance
    p_single_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_one_ws) |=> ($countones({bank0_start, bank1_start}) == 1));

    // R9: a configuration change leaves no word held
    p_cfg_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!bk_held[0] && !bk_held[1]));

endmodule

// File: tb/flash_ilv_reader_test.sv
module flash_ilv_reader_test;

    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int CLK = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_one_ws = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-2:0] bank0_addr, bank1_addr;
    logic          bank0_start, bank1_start;
    logic [DW-1:0] bank0_rdata, bank1_rdata;

    int vec = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    // model of held words and wait-state mode
    bit            m_ws = 0;
    bit            m_held [2];
    logic [AW-1:0] m_word [2];

    logic [DW-1:0] q_data [$];
    int            q_due  [$];
    string         q_tag  [$];

    int age0 = 3, age1 = 3;

    always #(CLK/2) clk = ~clk;

    flash_ilv_reader #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_one_ws(cfg_one_ws),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bank0_addr(bank0_addr), .bank0_start(bank0_start), .bank0_rdata(bank0_rdata),
        .bank1_addr(bank1_addr), .bank1_start(bank1_start), .bank1_rdata(bank1_rdata)
    );

    function automatic logic [DW-1:0] stored(input logic [AW-1:0] w);
        return ({20'h0, w} * 32'h0001_0103) ^ 32'hC3A5_0000;
    endfunction

    // flash bank models: data is good only once the address has settled
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bank0_start) age0 <= 1; else if (age0 < 3) age0 <= age0 + 1;
        if (bank1_start) age1 <= 1; else if (age1 < 3) age1 <= age1 + 1;
    end

    logic ok0, ok1;
    assign ok0 = bank0_start ? (m_ws == 0) : (age0 >= int'(m_ws));
    assign ok1 = bank1_start ? (m_ws == 0) : (age1 >= int'(m_ws));
    assign bank0_rdata = ok0 ? stored({bank0_addr, 1'b0}) : ~stored({bank0_addr, 1'b0});
    assign bank1_rdata = ok1 ? stored({bank1_addr, 1'b1}) : ~stored({bank1_addr, 1'b1});

    task automatic chk(input bit cond, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vec++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: called at a negative edge; pushes the expected item before the accepting edge
    task automatic rd(input logic [AW-1:0] a, input string tag);
        bit b;
        bit h;
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        b = a[0];
        if (!m_ws) begin
            m_held[0] = 0;
            m_held[1] = 0;
            q_due.push_back(cyc + 1);
        end else begin
            h = m_held[b] && (m_word[b] == a);
            q_due.push_back(h ? cyc + 1 : cyc + 2);
            m_held[0] = 1;
            m_held[1] = 1;
            m_word[b]  = a;
            m_word[~b] = a + AW'(1);
        end
        q_data.push_back(stored(a));
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_ws(input bit v);
        cfg_one_ws = v;
        m_ws = v;
        m_held[0] = 0;
        m_held[1] = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    chk(0, "R7", "response with nothing expected", 32'd1, 32'd0);
                end else begin
                    chk(rsp_data == q_data[0], "R7", "data", rsp_data, q_data[0]);
                    chk(cyc == q_due[0], q_tag[0], "response cycle",
                        32'(cyc), 32'(q_due[0]));
                    void'(q_data.pop_front());
                    void'(q_due.pop_front());
                    void'(q_tag.pop_front());
                end
            end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
                chk(0, q_tag[0], "missing response", 32'(cyc), 32'(q_due[0]));
                void'(q_data.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end
            if (!m_ws && (bank0_start || bank1_start)) begin
                // R10: no fetch ahead with zero wait states
                chk(!(bank0_start && bank1_start), "R10", "both banks started",
                    32'({bank0_start, bank1_start}), 32'd1);
            end
        end
    end

    initial begin
        #(CLK * 100000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        m_held[0] = 0;
        m_held[1] = 0;
        m_word[0] = '0;
        m_word[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(req_ready == 1'b1, "R8", "req_ready after reset", 32'(req_ready), 32'd1);
        started = 1;

        // R2 / R1: zero wait states, mixed banks, back to back
        rd(12'd5, "R2");
        rd(12'd6, "R2");
        rd(12'd100, "R1");
        rd(12'd3, "R1");
        idle(3);

        // R3 then R6: burst in one-wait-state mode
        set_ws(1);
        rd(12'd20, "R3");
        for (int i = 21; i < 28; i++) rd(AW'(i), "R6");
        idle(3);

        // R11: jump away discards prefetch; R4: repeat and held words hit
        rd(12'd40, "R11");
        rd(12'd41, "R5");
        rd(12'd10, "R11");
        rd(12'd10, "R4");
        rd(12'd11, "R4");
        idle(2);

        // R11: wrap from top word to word 0
        rd(12'd4095, "R11");
        rd(12'd0, "R11");
        idle(2);

        // R4: held prefetch survives idle cycles
        rd(12'd70, "R3");
        idle(2);
        rd(12'd71, "R4");
        idle(2);

        // R9: mode change drops held words
        rd(12'd60, "R3");
        rd(12'd61, "R5");
        idle(2);
        set_ws(0);
        set_ws(1);
        rd(12'd62, "R9");
        rd(12'd63, "R6");
        idle(4);

        chk(q_data.size() == 0, "R7", "responses outstanding",
            32'(q_data.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule